// File: doc/BRIEF.md
# Dual-Scan Monochrome LCD Timing Generator

This block produces the timing for a dual-scan monochrome panel that takes 8 data bits per shift. Each shift carries data for both panel halves, and both halves are scanned in step. Every timing value is counted in pixel-clock periods. The block produces a line pulse, a frame pulse, a gated shift clock, an alternating-polarity (MOD) signal and the 8-bit panel data bus. Pixel words come from an upstream feed. The feed offers a word with `pix_valid`, and the block takes it with a one-cycle `pix_take` strobe.

Three fields set the geometry: a display width field W, a non-display width field N and a line count field V. The block copies these fields, together with the shift-gating enable, into shadow registers at the start of each frame. A write in the middle of a frame therefore never breaks the current frame. In the requirements below, t is the pixel-clock index within a line. At t = 0 the line pulse has just fallen. P is the line period.

Top module: `dscan_lcd_timer`

## Requirements
- R1: While `rst_n` is low, every output is low. On the first clock after release the block loads its shadow fields and shows t = 0 of line 0.
- R2: The line period is P = 16·(W+1) + 16·(N+4) clocks, where W is the 7-bit `disp_width` value and N is the 5-bit `blank_width` value. `line_pulse` is high for the last 9 clocks of each line, t = P-9 to P-1.
- R3: `frame_pulse` rises at t = 9 of the last line of a frame and stays high until t = 8 of line 0 of the next frame. It therefore rises P-9 clocks before the line-pulse fall that opens line 0 and falls 9 clocks after that fall.
- R4: `mod_out` toggles once per frame, at t = 1 of line 0, which is 1 clock after the line-pulse falling edge.
- R5: Inside the active window, t = 39 to 16·(W+1)+38, `shift_clk` is high at t = 39+8j to 42+8j for j = 0 to 2·(W+1)-1. The first rise is at t = 39 and the falls are at t = 43+8j. The last fall comes 16·N+29 clocks before the next line-pulse fall.
- R6: With the shadowed `shift_gate` at 1, `shift_clk` stays low outside the active window. With it at 0, `shift_clk` keeps the same 8-clock, 4-high phase through the whole line.
- R7: Word j appears on `panel_data` from t = 39+8j to 46+8j. That is 4 clocks either side of its shift fall. If no word was valid when the slot was fetched, the bus shows 0. Outside the window the bus is 0.
- R8: Word j is fetched at t = 38+8j. `pix_take` is high in that cycle only if `pix_valid` is high, and the word on `pix_data` is captured at that clock edge.
- R9: A frame holds V+1 line periods, where V is the `frame_lines` value. With V = 0, `frame_pulse` stays high all the time.
- R10: A change to `disp_width`, `blank_width`, `frame_lines` or `shift_gate` takes effect only at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_width | input | 7 | Display width field W |
| blank_width | input | 5 | Non-display width field N |
| frame_lines | input | 9 | Lines per frame minus one (V) |
| shift_gate | input | 1 | 1 = hold the shift clock low outside the active window |
| pix_data | input | 8 | Offered pixel word |
| pix_valid | input | 1 | Offered word is valid |
| pix_take | output | 1 | Word taken at this clock edge |
| frame_pulse | output | 1 | Frame pulse |
| line_pulse | output | 1 | Line pulse |
| shift_clk | output | 1 | Shift clock |
| mod_out | output | 1 | Alternating-polarity (MOD) signal |
| panel_data | output | 8 | Panel data bus |

## Verification
The hardest case to reach is a field write that lands in the middle of a frame. The write must leave the rest of that frame unchanged and must then take effect exactly at the wrap from the last line to line 0. The stimulus changes all three geometry fields part-way through a multi-line frame and keeps the run going across several later frames. A behavioural per-cycle model tracks the shadow copies on its own, so every line pulse that follows is compared against the period that should apply. Separate runs cover gaps in `pix_valid`, a one-line frame, and the shift clock with gating off.

// File: rtl/dscan_lcd_timer.sv
module dscan_lcd_timer #(
  parameter int HDW_W = 7,
  parameter int HNDP_W = 5,
  parameter int VL_W = 9,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HDW_W-1:0]  disp_width,
  input  logic [HNDP_W-1:0] blank_width,
  input  logic [VL_W-1:0]   frame_lines,
  input  logic              shift_gate,
  input  logic [DW-1:0]     pix_data,
  input  logic              pix_valid,
  output logic              pix_take,
  output logic              frame_pulse,
  output logic              line_pulse,
  output logic              shift_clk,
  output logic              mod_out,
  output logic [DW-1:0]     panel_data
);
  localparam int HW = ((HDW_W > HNDP_W) ? HDW_W : HNDP_W) + 6;
  localparam int LP_LEN = 9;
  localparam int FIRST_HI = 39;

  logic              run;
  logic              mod_q;
  logic              mq;
  logic [HW-1:0]     h;
  logic [VL_W-1:0]   v, vq;
  logic [HDW_W-1:0]  wq;
  logic [HNDP_W-1:0] nq;
  logic [DW-1:0]     dat;

  logic [HW-1:0] act_len, period, win_end;
  logic [2:0]    ph;
  logic          line_end, frame_end, in_win, slot, phase_hi;

  assign act_len   = (HW'(wq) + HW'(1)) << 4;
  assign period    = act_len + ((HW'(nq) + HW'(4)) << 4);
  assign win_end   = act_len + HW'(FIRST_HI - 1);
  assign line_end  = (h == period - HW'(1));
  assign frame_end = line_end && (v == vq);
  assign in_win    = (h >= HW'(FIRST_HI)) && (h <= win_end);
  assign slot      = (h >= HW'(FIRST_HI - 1)) && (h <= win_end - HW'(8)) && (h[2:0] == 3'd6);
  assign ph        = h[2:0] + 3'd1;
  assign phase_hi  = !ph[2];

  assign pix_take    = run && slot && pix_valid;
  assign line_pulse  = run && (h >= period - HW'(LP_LEN));
  assign frame_pulse = run && (((v == vq) && (h >= HW'(LP_LEN))) ||
                               ((v == '0) && (h < HW'(LP_LEN))));
  assign shift_clk   = run && phase_hi && (in_win || !mq);
  assign mod_out     = mod_q;
  assign panel_data  = dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      mod_q <= 1'b0;
      h     <= '0;
      v     <= '0;
      wq    <= '0;
      nq    <= '0;
      vq    <= '0;
      mq    <= 1'b0;
      dat   <= '0;
    end else if (!run) begin
      run <= 1'b1;
      wq  <= disp_width;
      nq  <= blank_width;
      vq  <= frame_lines;
      mq  <= shift_gate;
    end else begin
      if (slot)
        dat <= pix_valid ? pix_data : '0;
      else if (h == win_end)
        dat <= '0;
      if (h == '0 && v == '0)
        mod_q <= ~mod_q;
      if (line_end) begin
        h <= '0;
        v <= frame_end ? '0 : v + VL_W'(1);
      end else begin
        h <= h + HW'(1);
      end
      if (frame_end) begin
        wq <= disp_width;
        nq <= blank_width;
        vq <= frame_lines;
        mq <= shift_gate;
      end
    end
  end
endmodule

// File: rtl/dscan_lcd_timer_chk.sv
module dscan_lcd_timer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_take,
  input logic          frame_pulse,
  input logic          line_pulse,
  input logic          shift_clk,
  input logic          mod_out,
  input logic [DW-1:0] panel_data
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else if (!line_pulse && $past(line_pulse)) seen <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      // R1
      reset_quiet_chk: assert (!pix_take && !frame_pulse && !line_pulse &&
                               !shift_clk && !mod_out && panel_data == '0);
    end
  end

  // R2
  lp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_pulse) |-> $past(line_pulse, 9) && !$past(line_pulse, 10));

  // R3
  fp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_pulse) && seen) |-> $past(line_pulse, 10) && !$past(line_pulse, 9));

  // R4
  mod_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mod_out) && seen) |-> $past(line_pulse, 2) && !$past(line_pulse, 1));

  // R5
  shift_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(shift_clk) && seen) |-> $past(shift_clk, 4) && !$past(shift_clk, 5));

  // R7
  data_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_clk) |-> $stable(panel_data));

  // R7
  data_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(panel_data) && panel_data != '0) |-> $past(pix_take));

  // R8
  take_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_take |=> shift_clk);
endmodule

bind dscan_lcd_timer dscan_lcd_timer_chk #(.DW(DW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .pix_take(pix_take),
  .frame_pulse(frame_pulse),
  .line_pulse(line_pulse),
  .shift_clk(shift_clk),
  .mod_out(mod_out),
  .panel_data(panel_data)
);

// File: tb/dscan_lcd_timer_test.sv
module dscan_lcd_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [6:0] disp_width = '0;
  logic [4:0] blank_width = '0;
  logic [8:0] frame_lines = '0;
  logic       shift_gate = 1'b1;
  logic [7:0] pix_data = 8'h01;
  logic       pix_valid = 1'b1;
  logic       pix_take, frame_pulse, line_pulse, shift_clk, mod_out;
  logic [7:0] panel_data;

  dscan_lcd_timer uut (
    .clk(clk), .rst_n(rst_n), .disp_width(disp_width), .blank_width(blank_width),
    .frame_lines(frame_lines), .shift_gate(shift_gate), .pix_data(pix_data),
    .pix_valid(pix_valid), .pix_take(pix_take), .frame_pulse(frame_pulse),
    .line_pulse(line_pulse), .shift_clk(shift_clk), .mod_out(mod_out),
    .panel_data(panel_data)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, valid_mode = 0;
  int m_run = 0, m_t = 0, m_v = 0, m_w = 0, m_n = 0, m_vl = 0, m_mask = 0, m_mod = 0, m_dat = 0;
  bit last_take = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d t=%0d v=%0d: actual %0d expected %0d", tag, cyc, m_t, m_v, act, exp);
    end
  endtask

  function automatic int per();
    return 16 * (m_w + 1) + 16 * (m_n + 4);
  endfunction

  function automatic int wend();
    return 16 * (m_w + 1) + 38;
  endfunction

  function automatic bit is_slot();
    return m_t >= 38 && m_t <= wend() - 8 && (m_t % 8) == 6;
  endfunction

  task automatic load();
    m_w = disp_width; m_n = blank_width; m_vl = frame_lines; m_mask = shift_gate;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_t = 0; m_v = 0; m_w = 0; m_n = 0; m_vl = 0; m_mask = 0; m_mod = 0; m_dat = 0;
    end else if (m_run == 0) begin
      m_run = 1;
      load();
    end else begin
      if (is_slot()) m_dat = pix_valid ? int'(pix_data) : 0;
      else if (m_t == wend()) m_dat = 0;
      if (m_t == 0 && m_v == 0) m_mod ^= 1;
      if (m_t == per() - 1) begin
        m_t = 0;
        if (m_v == m_vl) begin m_v = 0; load(); end
        else m_v++;
      end else m_t++;
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    bit pend, inw, hi;
    int e_lp, e_fp, e_sh, e_tk;
    last_take = pix_take;
    if (!rst_n) begin
      chk("R1 line_pulse", line_pulse, 0);
      chk("R1 frame_pulse", frame_pulse, 0);
      chk("R1 shift_clk", shift_clk, 0);
      chk("R1 mod_out", mod_out, 0);
      chk("R1 panel_data", panel_data, 0);
      chk("R1 pix_take", pix_take, 0);
    end else begin
      pend = (disp_width != m_w) || (blank_width != m_n) || (frame_lines != m_vl) || (shift_gate != m_mask);
      inw = m_t >= 39 && m_t <= wend();
      hi = ((m_t + 1) % 8) < 4;
      e_lp = (m_run != 0 && m_t >= per() - 9) ? 1 : 0;
      e_fp = (m_run != 0 && ((m_v == m_vl && m_t >= 9) || (m_v == 0 && m_t < 9))) ? 1 : 0;
      e_sh = (m_run != 0 && hi && (inw || m_mask == 0)) ? 1 : 0;
      e_tk = (m_run != 0 && is_slot() && pix_valid) ? 1 : 0;
      chk(pend ? "R10 line_pulse" : "R2 line_pulse", line_pulse, e_lp);
      chk(m_v != 0 ? "R9 frame_pulse" : "R3 frame_pulse", frame_pulse, e_fp);
      chk(inw ? "R5 shift_clk" : "R6 shift_clk", shift_clk, e_sh);
      chk("R4 mod_out", mod_out, m_mod);
      chk("R7 panel_data", panel_data, m_dat);
      chk("R8 pix_take", pix_take, e_tk);
    end
  end

  always @(posedge clk) begin
    #1;
    if (last_take) pix_data <= pix_data + 8'd1;
    pix_valid <= (valid_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
  endtask

  initial begin
    #1;
    // R1 R2 R3 R5: narrowest line, gated shift clock, three lines per frame
    disp_width = 7'd0; blank_width = 5'd0; frame_lines = 9'd2; shift_gate = 1'b1;
    do_reset();
    wait_cyc(3 * 240 + 100);
    // R10: geometry changed in the middle of a frame
    disp_width = 7'd2; blank_width = 5'd1; frame_lines = 9'd1;
    wait_cyc(4 * 256 + 50);
    // R6 R7 R8: ungated shift clock with gaps in the feed
    valid_mode = 1;
    disp_width = 7'd1; blank_width = 5'd3; frame_lines = 9'd3; shift_gate = 1'b0;
    do_reset();
    wait_cyc(3 * 576 + 40);
    // R9: one line per frame
    valid_mode = 0;
    disp_width = 7'd3; blank_width = 5'd0; frame_lines = 9'd0; shift_gate = 1'b1;
    do_reset();
    wait_cyc(5 * 128 + 30);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule